// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM

This block is a small, parameterized memory with a read port and a write port. The two ports work independently but share one address bus. Each address holds a line of four words. A line always moves as a burst of four words. Each word takes one half-cycle, so both data buses run at double data rate. The block has one clock input, `clk`. Each rising edge of `clk` stands for one rising edge of the complementary input clock pair. The edges alternate: first the true phase (K), then the complement phase (K#). The first edge after reset is a K edge.

A read is requested on a K edge. The read address is taken from the shared bus on that edge. The write address is taken on the K# edge that follows a write request. This way both ports can use the single address bus in the same clock cycle. Read data leaves through a registered output after a fixed latency. A valid flag and an echo strobe pair come with it. A read whose first word leaves on the same edge that a write to the same line completes returns the new data.

Top module: `qdrb_sram`

## Requirements
- R1: `echoQ` is high after every K edge and low after every K# edge. `echoQn` is always its complement. Both are low/high respectively during reset, and the first edge after reset is a K edge.
- R2: In reset and directly after it, `rdValid` and `rdData` are 0.
- R3: If `rdSelN` is low at a K edge, the read address is latched on that edge. Word 0 of the line (bits [DW-1:0]) appears on `rdData` after the RD_LAT-th following edge. RD_LAT is 3 by default. Words 1, 2 and 3 (word i at bits [DW*i +: DW]) follow on the next three edges.
- R4: `rdValid` is high for exactly four half-cycles per burst. While no burst is running, `rdValid` is low and `rdData` keeps the last word sent.
- R5: A read request on the K edge two half-cycles after an accepted read is ignored. A read request four half-cycles after an accepted read is accepted. Its burst follows the previous one with no gap in `rdValid`.
- R6: `rdSelN` and `wrSelN` are sampled only on K edges. If either select is low on a K# edge only, no read or write is started.
- R7: If `wrSelN` is low at a K edge, a write starts. Word 0 is taken on that edge. The write address and word 1 are taken on the next K# edge. Words 2 and 3 are taken on the following K and K# edges. The line is updated when word 3 is taken.
- R8: A low `wrSelN` on the K edge during a write burst in progress is ignored. The address bus on the following K# edge is not used.
- R9: A read whose word 0 leaves on the edge that completes a write to the same line returns the newly written words. A read whose word 0 leaves before that edge returns the old line.
- R10: A read and a write to different lines can run in the same cycles without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; its rising edges alternate K and K# |
| rstN | input | 1 | Active-low synchronous reset |
| rdSelN | input | 1 | Active-low read request, sampled on K edges |
| wrSelN | input | 1 | Active-low write request, sampled on K edges |
| addr | input | AW | Shared address bus: read address on K, write address on K# |
| wrData | input | DW | Write data word, one per edge during a write burst |
| rdData | output | DW | Registered read data word |
| rdValid | output | 1 | High while a burst word is on `rdData` |
| echoQ | output | 1 | Echo strobe, high after K edges |
| echoQn | output | 1 | Complement of `echoQ` |

## Verification
A broken phase register would swap which edges accept requests. That shows up at once: `echoQ` is inverted, and a read issued on a K edge never brings `rdValid` high RD_LAT edges later. A wrong burst counter or word index shows within the four-word burst as a word in the wrong position or a valid pulse of the wrong length. A write sequencer that starts twice, or takes the address on the wrong edge, shows only when the damaged line is read back later. The scenarios therefore read back every line they could have touched. The forwarding path is exercised on the single edge where the final write word and the read launch meet. It is also exercised two edges earlier, where the old line must be returned.

// File: rtl/qdrb_pkg.sv
package qdrb_pkg;
  // Per-edge strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       rdCapture;  // latch read address from the shared bus
    logic       rdLoad;     // fetch line, send word 0
    logic       rdShift;    // send the next buffered word
    logic [1:0] rdIdx;      // which buffered word to send
    logic       wrWord0;    // take write word 0
    logic       wrWord1;    // take write word 1 and the write address
    logic       wrWord2;    // take write word 2
    logic       wrCommit;   // take word 3 and update the line
  } qdrbStrobe_t;
endpackage

// File: rtl/qdrb_ctrl.sv
module qdrb_ctrl
  import qdrb_pkg::*;
#(
  parameter int RD_LAT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdSelN,
  input  logic        wrSelN,
  output qdrbStrobe_t strobe,
  output logic        rdValid,
  output logic        kNext
);
  logic              rdHold;
  logic [RD_LAT-1:0] vPipe;
  logic [1:0]        rdLeft;
  logic [1:0]        wrStep;
  logic              rdValidQ;
  logic              rdAccept;
  logic              wrStart;
  logic              launch;

  // Requests are only taken on K edges.
  assign rdAccept = kNext & ~rdSelN & ~rdHold;
  assign wrStart  = kNext & ~wrSelN & (wrStep == 2'd0);
  assign launch   = vPipe[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kNext    <= 1'b1;
      rdHold   <= 1'b0;
      vPipe    <= '0;
      rdLeft   <= 2'd0;
      wrStep   <= 2'd0;
      rdValidQ <= 1'b0;
    end else begin
      kNext <= ~kNext;
      if (kNext) rdHold <= rdAccept;
      vPipe <= {vPipe[RD_LAT-2:0], rdAccept};
      if (launch) begin
        rdLeft   <= 2'd3;
        rdValidQ <= 1'b1;
      end else if (rdLeft != 2'd0) begin
        rdLeft <= rdLeft - 2'd1;
      end else begin
        rdValidQ <= 1'b0;
      end
      if (wrStart) wrStep <= 2'd1;
      else if (wrStep != 2'd0) wrStep <= wrStep + 2'd1;
    end
  end

  always_comb begin
    strobe.rdCapture = rdAccept;
    strobe.rdLoad    = launch;
    strobe.rdShift   = ~launch & (rdLeft != 2'd0);
    strobe.rdIdx     = 2'd0 - rdLeft;
    strobe.wrWord0   = wrStart;
    strobe.wrWord1   = (wrStep == 2'd1);
    strobe.wrWord2   = (wrStep == 2'd2);
    strobe.wrCommit  = (wrStep == 2'd3);
  end

  assign rdValid = rdValidQ;

  // R5
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAccept |=> ##1 !rdAccept);

  // R7
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCommit |-> $past(wrStart, 3));

  // R4
  valid_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValidQ) |=> rdValidQ ##1 rdValidQ ##1 rdValidQ);
endmodule

// File: rtl/qdrb_datapath.sv
module qdrb_datapath
  import qdrb_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int RD_LAT = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  qdrbStrobe_t   strobe,
  output logic [DW-1:0] rdData
);
  localparam int WORDS  = 4;
  localparam int LINE_W = WORDS * DW;
  localparam int DEPTH  = 1 << AW;

  logic [LINE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     addrPipe [RD_LAT];
  logic [AW-1:0]     wrAddr;
  logic [DW-1:0]     wrBuf [3];
  logic [LINE_W-1:0] lineBuf;
  logic [DW-1:0]     rdDataQ;
  logic [LINE_W-1:0] commitLine;
  logic [LINE_W-1:0] fetchLine;
  logic              fwdHit;

  // Read address pipeline, one stage per half-cycle of latency.
  always_ff @(posedge clk) begin
    if (strobe.rdCapture) addrPipe[0] <= addr;
  end

  for (genvar i = 1; i < RD_LAT; i++) begin : g_addrPipe
    always_ff @(posedge clk) addrPipe[i] <= addrPipe[i-1];
  end

  // Write word assembly.
  always_ff @(posedge clk) begin
    if (strobe.wrWord0) wrBuf[0] <= wrData;
    if (strobe.wrWord1) begin
      wrBuf[1] <= wrData;
      wrAddr   <= addr;
    end
    if (strobe.wrWord2) wrBuf[2] <= wrData;
  end

  assign commitLine = {wrData, wrBuf[2], wrBuf[1], wrBuf[0]};

  always_ff @(posedge clk) begin
    if (strobe.wrCommit) mem[wrAddr] <= commitLine;
  end

  // Coherent fetch: a line completing on this edge wins over the array.
  assign fwdHit    = strobe.wrCommit && (wrAddr == addrPipe[RD_LAT-1]);
  assign fetchLine = fwdHit ? commitLine : mem[addrPipe[RD_LAT-1]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBuf <= '0;
      rdDataQ <= '0;
    end else if (strobe.rdLoad) begin
      lineBuf <= fetchLine;
      rdDataQ <= fetchLine[DW-1:0];
    end else if (strobe.rdShift) begin
      rdDataQ <= lineBuf[strobe.rdIdx*DW +: DW];
    end
  end

  assign rdData = rdDataQ;

  // R9
  fwd_new_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && strobe.wrCommit && (wrAddr == addrPipe[RD_LAT-1]))
      |=> (rdDataQ == $past(wrBuf[0])));
endmodule

// File: rtl/qdrb_sram.sv
module qdrb_sram
  import qdrb_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int RD_LAT = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdSelN,
  input  logic          wrSelN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          echoQ,
  output logic          echoQn
);
  qdrbStrobe_t strobe;
  logic        kNext;

  qdrb_ctrl #(.RD_LAT(RD_LAT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .strobe (strobe),
    .rdValid(rdValid),
    .kNext  (kNext)
  );

  qdrb_datapath #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrData (wrData),
    .strobe (strobe),
    .rdData (rdData)
  );

  // Echo strobes, registered alongside the data.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      echoQ  <= 1'b0;
      echoQn <= 1'b1;
    end else begin
      echoQ  <= kNext;
      echoQn <= ~kNext;
    end
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdData));
endmodule

// File: tb/qdrb_sram_bench.sv
module qdrb_sram_bench;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdSelN = 1'b1;
  logic          wrSelN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic          echoQ;
  logic          echoQn;

  int nChecks = 0;
  int nFails  = 0;
  bit tbK = 1'b1;
  logic [31:0] refMem [16];

  qdrb_sram #(.DW(DW), .AW(AW), .RD_LAT(LAT)) u_qdrb_sram (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .echoQ(echoQ), .echoQn(echoQn)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) tbK <= 1'b1;
    else tbK <= ~tbK;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic alignK();
    if (!tbK) tick();
  endtask

  task automatic idle(input int n);
    rdSelN = 1'b1;
    wrSelN = 1'b1;
    repeat (n) tick();
  endtask

  // Plain write burst (R7).
  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] ln);
    alignK();
    wrSelN = 1'b0; wrData = ln[7:0]; tick();
    wrSelN = 1'b1; addr = a; wrData = ln[15:8]; tick();
    wrData = ln[23:16]; tick();
    wrData = ln[31:24]; tick();
    refMem[a] = ln;
  endtask

  // Up to two read requests at edge offsets s0/s1 from a K edge.
  task automatic readSeq(input string req, input int s0, input logic [AW-1:0] a0, input bit acc0,
                         input int s1, input logic [AW-1:0] a1, input bit acc1, input int n);
    logic [31:0] l0;
    logic [31:0] l1;
    logic [7:0]  last;
    bit          haveLast;
    l0 = refMem[a0];
    l1 = refMem[a1];
    last = '0;
    haveLast = 1'b0;
    alignK();
    for (int k = 0; k < n; k++) begin
      rdSelN = !((k == s0) || (k == s1));
      addr   = (k == s1) ? a1 : a0;
      tick();
      if (acc0 && k >= s0 + LAT && k <= s0 + LAT + 3) begin
        chk({req, " valid"}, 32'(rdValid), 32'd1);
        chk({req, " word"}, 32'(rdData), 32'(l0[8*(k-s0-LAT) +: 8]));
        last = l0[8*(k-s0-LAT) +: 8];
        haveLast = 1'b1;
      end else if (acc1 && k >= s1 + LAT && k <= s1 + LAT + 3) begin
        chk({req, " valid"}, 32'(rdValid), 32'd1);
        chk({req, " word"}, 32'(rdData), 32'(l1[8*(k-s1-LAT) +: 8]));
        last = l1[8*(k-s1-LAT) +: 8];
        haveLast = 1'b1;
      end else begin
        chk({req, " idle valid"}, 32'(rdValid), 32'd0);
        if (haveLast) chk({req, " R4 hold"}, 32'(rdData), 32'(last));
      end
    end
    rdSelN = 1'b1;
  endtask

  // Write at edge w (w<0: none), extra write select at edge ex with eAddr on the
  // bus one edge later, and one read of ra at edge r expecting expLine.
  task automatic mixSeq(input string req, input int w, input logic [AW-1:0] wa,
                        input logic [31:0] ln, input int ex, input logic [AW-1:0] eAddr,
                        input int r, input logic [AW-1:0] ra, input logic [31:0] expLine,
                        input int n);
    alignK();
    for (int k = 0; k < n; k++) begin
      rdSelN = !(k == r);
      wrSelN = !((w >= 0 && k == w) || (ex >= 0 && k == ex));
      if (w >= 0 && k >= w && k <= w + 3) wrData = ln[8*(k-w) +: 8];
      else wrData = 8'hEE;
      addr = '0;
      if (k == r) addr = ra;
      else if (w >= 0 && k == w + 1) addr = wa;
      else if (ex >= 0 && k == ex + 1) addr = eAddr;
      tick();
      if (k >= r + LAT && k <= r + LAT + 3) begin
        chk({req, " valid"}, 32'(rdValid), 32'd1);
        chk({req, " word"}, 32'(rdData), 32'(expLine[8*(k-r-LAT) +: 8]));
      end
    end
    if (w >= 0) refMem[wa] = ln;
    idle(2);
  endtask

  task automatic testReset();
    chk("R2 rdValid", 32'(rdValid), 32'd0);
    chk("R2 rdData", 32'(rdData), 32'd0);
    chk("R1 echoQ reset", 32'(echoQ), 32'd0);
    chk("R1 echoQn reset", 32'(echoQn), 32'd1);
    tick();
    chk("R1 echoQ after K", 32'(echoQ), 32'd1);
    chk("R1 echoQn after K", 32'(echoQn), 32'd0);
    tick();
    chk("R1 echoQ after K#", 32'(echoQ), 32'd0);
    chk("R1 echoQn after K#", 32'(echoQn), 32'd1);
    chk("R2 rdValid idle", 32'(rdValid), 32'd0);
  endtask

  task automatic testFillAndRead();
    for (int a = 0; a < 16; a++)
      doWrite(4'(a), (32'h5A3C_0F81 ^ (32'(a) * 32'h0103_0507)) + 32'(a));
    idle(1);
    readSeq("R3 R7 line 0", 0, 4'd0, 1'b1, -8, 4'd0, 1'b0, 9);
    readSeq("R3 R7 line 9", 0, 4'd9, 1'b1, -8, 4'd0, 1'b0, 9);
    readSeq("R3 R7 line 15", 0, 4'd15, 1'b1, -8, 4'd0, 1'b0, 9);
    doWrite(4'd6, 32'hFF00_FF00);
    readSeq("R7 overwrite", 0, 4'd6, 1'b1, -8, 4'd0, 1'b0, 9);
  endtask

  task automatic testBackToBack();
    readSeq("R5 seamless", 0, 4'd3, 1'b1, 4, 4'd12, 1'b1, 13);
  endtask

  task automatic testTooClose();
    readSeq("R5 ignored", 0, 4'd4, 1'b1, 2, 4'd11, 1'b0, 11);
  endtask

  task automatic testKbarRead();
    readSeq("R6 read on K#", 1, 4'd5, 1'b0, -8, 4'd0, 1'b0, 8);
  endtask

  task automatic testKbarWrite();
    logic [31:0] old;
    old = refMem[4'd7];
    mixSeq("R6 write on K#", -1, 4'd0, 32'h0, 1, 4'd7, 6, 4'd7, old, 12);
  endtask

  task automatic testWrBusy();
    logic [31:0] oldB;
    oldB = refMem[4'd8];
    mixSeq("R8 busy write", 0, 4'd2, 32'h1122_3344, 2, 4'd8, 8, 4'd8, oldB, 14);
    readSeq("R8 first write kept", 0, 4'd2, 1'b1, -8, 4'd0, 1'b0, 9);
  endtask

  task automatic testCoherent();
    logic [31:0] oldL;
    mixSeq("R9 same-edge forward", 0, 4'd10, 32'hC0DE_BEEF, -1, 4'd0, 0, 4'd10, 32'hC0DE_BEEF, 9);
    oldL = refMem[4'd11];
    mixSeq("R9 early launch old", 2, 4'd11, 32'h7766_5544, -1, 4'd0, 0, 4'd11, oldL, 9);
    readSeq("R9 line 11 updated", 0, 4'd11, 1'b1, -8, 4'd0, 1'b0, 9);
  endtask

  task automatic testConcurrent();
    logic [31:0] other;
    other = refMem[4'd1];
    mixSeq("R10 concurrent", 0, 4'd13, 32'hA1B2_C3D4, -1, 4'd0, 0, 4'd1, other, 9);
    readSeq("R10 written line", 0, 4'd13, 1'b1, -8, 4'd0, 1'b0, 9);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    testReset();
    testFillAndRead();
    testBackToBack();
    testTooClose();
    testKbarRead();
    testKbarWrite();
    testWrBusy();
    testCoherent();
    testConcurrent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule